// File: doc/BRIEF.md
# Tree Up-Down Hop Router

This block makes the forwarding decision for one hop of a packet travelling through a k-ary tree, where k is a power of two. A node address is a string of radix-k digits. Digit 0 is the least significant, and the digits together spell the path from the root down to the node. The block takes one header at a time over a valid/ready handshake. It returns a registered decision one cycle later: deliver locally, climb toward the root, or descend through one of the k child ports.

The same unit serves both ends of the route. When a header is injected at the source, the unit XORs the source and destination addresses. It locates the highest differing digit and derives from it how many levels the packet must climb to reach the common ancestor. The first climb hop is taken at once, and the number of hops still to climb is written into the header. At a switch, a transit header with a nonzero remaining-climb count goes up again, and the count is decremented. Once the count is zero, the packet descends. At each level the child port is that level's digit of the destination, and the switch's level comes from a configuration input. When a switch has several parents, upward hops take turns among them through a rotating pointer.

Top module: `tree_route_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The first upward decision after reset selects parent 0.
- R2: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R3: A header accepted on a clock edge (`in_valid` and `in_ready` both 1) gives `out_valid` = 1 after that edge. With no acceptance and `out_ready` = 1, `out_valid` drops to 0.
- R4: For an injected header (`in_inject` = 1) with different addresses, the climb count is c = (index of the most significant differing digit of `in_src` XOR `in_dst`) + 1. The decision is UP (`out_kind` = 1) with `out_up_rem` = c - 1.
- R5: For an injected header with equal source and destination, the decision is LOCAL (`out_kind` = 0) with `out_up_rem` = 0.
- R6: For a transit header (`in_inject` = 0) with `in_up_rem` > 0, the decision is UP (`out_kind` = 1) with `out_up_rem` = `in_up_rem` - 1, whatever the addresses.
- R7: For a transit header with `in_up_rem` = 0, the decision is DOWN (`out_kind` = 2). `out_port` is digit L of `in_dst`, meaning bits [L*log2(k) +: log2(k)], where L is `cfg_level` at acceptance.
- R8: Each accepted UP decision uses the parent index that follows the one used by the previous UP decision. The index wraps from PARENTS-1 to 0, and LOCAL or DOWN decisions do not move it.
- R9: `out_port` is 0 unless the decision is DOWN, and `out_parent` is 0 unless it is UP. `out_dst` equals the accepted destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | LW | Level of this switch, 0 = switch next to nodes |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken |
| in_inject | input | 1 | 1 = header from the source, compute climb |
| in_src | input | AW | Source node address |
| in_dst | input | AW | Destination node address |
| in_up_rem | input | CW | Remaining levels to climb (transit headers) |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision consumed |
| out_kind | output | 2 | 0 LOCAL, 1 UP, 2 DOWN |
| out_port | output | DW | Child port for DOWN |
| out_parent | output | PW | Parent port for UP |
| out_up_rem | output | CW | Remaining-climb count for the next hop |
| out_dst | output | AW | Destination carried forward |

## Verification
A wrong climb count shows up as a bad `out_up_rem` or decision kind on the cycle right after the header is accepted. A stale or mis-advanced rotating pointer does not show up on its own hop. It appears on the next UP decision as the wrong `out_parent`, which may come many headers later, so the reference model tracks the pointer across LOCAL and DOWN traffic. A handshake fault, such as a dropped hold or a lost acceptance, appears within one cycle as a changed field under back-pressure or as a mismatch in `out_valid`.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
  typedef enum logic [1:0] {
    RK_LOCAL = 2'd0,
    RK_UP    = 2'd1,
    RK_DOWN  = 2'd2
  } route_kind_e;
endpackage

// File: rtl/tree_climb_calc.sv
// Climb count from the XOR of the two node addresses: one more than the
// index of the highest radix-k digit that differs.
module tree_climb_calc #(
  parameter  int RADIX  = 4,
  parameter  int LEVELS = 4,
  localparam int DW     = $clog2(RADIX),
  localparam int AW     = LEVELS * DW,
  localparam int CW     = $clog2(LEVELS + 1)
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  output logic [CW-1:0] climb,
  output logic          same_node
);
  logic [AW-1:0] rel;
  assign rel = src ^ dst;

  function automatic logic [CW-1:0] top_digit_plus1(input logic [AW-1:0] r);
    logic [CW-1:0] c;
    c = '0;
    for (int d = 0; d < LEVELS; d++) begin
      if (r[d*DW +: DW] != '0) c = CW'(d + 1);
    end
    return c;
  endfunction

  assign climb     = top_digit_plus1(rel);
  assign same_node = (rel == '0);
endmodule

// File: rtl/tree_hop_decide.sv
// Combinational per-hop decision: local, up (count down remaining climb), or down.
module tree_hop_decide
  import tree_route_pkg::*;
#(
  parameter  int RADIX  = 4,
  parameter  int LEVELS = 4,
  localparam int DW     = $clog2(RADIX),
  localparam int AW     = LEVELS * DW,
  localparam int CW     = $clog2(LEVELS + 1),
  localparam int LW     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic          inject,
  input  logic [CW-1:0] climb,
  input  logic [CW-1:0] up_rem,
  input  logic [AW-1:0] dst,
  input  logic [LW-1:0] level,
  output route_kind_e   kind,
  output logic [DW-1:0] port,
  output logic [CW-1:0] next_rem
);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  function automatic logic [DW-1:0] digit_at(input logic [AW-1:0] a,
                                             input logic [LW-1:0] lvl);
    logic [DW-1:0] g;
    g = '0;
    for (int j = 0; j < LEVELS; j++) begin
      if (lvl == LW'(j)) g = a[j*DW +: DW];
    end
    return g;
  endfunction

  always_comb begin
    kind     = RK_LOCAL;
    port     = '0;
    next_rem = '0;
    if (inject) begin
      if (climb != '0) begin
        kind     = RK_UP;
        next_rem = climb - ONE_C;
      end
    end else if (up_rem != '0) begin
      kind     = RK_UP;
      next_rem = up_rem - ONE_C;
    end else begin
      kind = RK_DOWN;
      port = digit_at(dst, level);
    end
  end
endmodule

// File: rtl/tree_parent_rr.sv
// Rotating choice among several parent ports; advances once per upward hop.
module tree_parent_rr #(
  parameter  int PARENTS = 3,
  localparam int PW      = (PARENTS > 1) ? $clog2(PARENTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [PW-1:0] ptr
);
  generate
    if (PARENTS == 1) begin : g_single
      assign ptr = '0;
    end else begin : g_multi
      localparam logic [PW-1:0] LAST_C = PW'(PARENTS - 1);
      logic [PW-1:0] ptr_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= (ptr_q == LAST_C) ? '0 : ptr_q + PW'(1);
      end
      assign ptr = ptr_q;
    end
  endgenerate
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
  import tree_route_pkg::*;
#(
  parameter  int RADIX   = 4,
  parameter  int LEVELS  = 4,
  parameter  int PARENTS = 3,
  localparam int DW      = $clog2(RADIX),
  localparam int AW      = LEVELS * DW,
  localparam int CW      = $clog2(LEVELS + 1),
  localparam int LW      = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PW      = (PARENTS > 1) ? $clog2(PARENTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_level,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_inject,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  input  logic [CW-1:0] in_up_rem,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [DW-1:0] out_port,
  output logic [PW-1:0] out_parent,
  output logic [CW-1:0] out_up_rem,
  output logic [AW-1:0] out_dst
);
  // Named internal events, visible to the bound checker.
  logic          accept;
  logic          up_taken;
  logic [CW-1:0] climb;
  logic          same_node;
  route_kind_e   dec_kind;
  logic [DW-1:0] dec_port;
  logic [CW-1:0] dec_rem;
  logic [PW-1:0] rr_ptr;

  tree_climb_calc #(.RADIX(RADIX), .LEVELS(LEVELS)) climb_i (
    .src(in_src), .dst(in_dst), .climb(climb), .same_node(same_node)
  );

  tree_hop_decide #(.RADIX(RADIX), .LEVELS(LEVELS)) decide_i (
    .inject(in_inject), .climb(climb), .up_rem(in_up_rem), .dst(in_dst),
    .level(cfg_level), .kind(dec_kind), .port(dec_port), .next_rem(dec_rem)
  );

  tree_parent_rr #(.PARENTS(PARENTS)) rr_i (
    .clk(clk), .rst_n(rst_n), .advance(up_taken), .ptr(rr_ptr)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign up_taken = accept && (dec_kind == RK_UP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_kind   <= RK_LOCAL;
      out_port   <= '0;
      out_parent <= '0;
      out_up_rem <= '0;
      out_dst    <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_kind   <= dec_kind;
      out_port   <= dec_port;
      out_parent <= (dec_kind == RK_UP) ? rr_ptr : '0;
      out_up_rem <= dec_rem;
      out_dst    <= in_dst;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/tree_route_unit_chk.sv
module tree_route_unit_chk
  import tree_route_pkg::*;
#(
  parameter  int RADIX   = 4,
  parameter  int LEVELS  = 4,
  parameter  int PARENTS = 3,
  localparam int DW      = $clog2(RADIX),
  localparam int AW      = LEVELS * DW,
  localparam int CW      = $clog2(LEVELS + 1),
  localparam int PW      = (PARENTS > 1) ? $clog2(PARENTS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_inject,
  input logic [AW-1:0] in_src,
  input logic [AW-1:0] in_dst,
  input logic [CW-1:0] in_up_rem,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_kind,
  input logic [DW-1:0] out_port,
  input logic [PW-1:0] out_parent,
  input logic [CW-1:0] out_up_rem,
  input logic [AW-1:0] out_dst,
  input logic          up_taken,
  input logic [PW-1:0] rr_ptr
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_port)
      && $stable(out_parent) && $stable(out_up_rem) && $stable(out_dst));

  // R3
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R3
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && out_ready |=> !out_valid);

  // R4
  inject_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_inject && (in_src != in_dst) |=> out_kind == RK_UP);

  // R5
  inject_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_inject && (in_src == in_dst) |=> out_kind == RK_LOCAL && out_up_rem == '0);

  // R6
  transit_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_inject && (in_up_rem != '0) |=>
      out_kind == RK_UP && out_up_rem == $past(in_up_rem) - CW'(1));

  // R7
  transit_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_inject && (in_up_rem == '0) |=> out_kind == RK_DOWN);

  // R8
  rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_taken |=> $stable(rr_ptr));

  // R8
  rr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rr_ptr <= PW'(PARENTS - 1));

  // R9
  port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != RK_DOWN |-> out_port == '0);

  // R9
  parent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind != RK_UP |-> out_parent == '0);

  // R9
  dst_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_dst == $past(in_dst));
endmodule

bind tree_route_unit tree_route_unit_chk #(
  .RADIX(RADIX), .LEVELS(LEVELS), .PARENTS(PARENTS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_inject(in_inject), .in_src(in_src), .in_dst(in_dst), .in_up_rem(in_up_rem),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_port(out_port), .out_parent(out_parent), .out_up_rem(out_up_rem),
  .out_dst(out_dst), .up_taken(up_taken), .rr_ptr(rr_ptr)
);

// File: tb/tree_route_unit_tb.sv
`timescale 1ns/1ps
module tree_route_unit_tb_top;
  localparam int RADIX = 4, LEVELS = 4, PARENTS = 3;
  localparam int DW = $clog2(RADIX), AW = LEVELS * DW, CW = $clog2(LEVELS + 1);
  localparam int LW = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int PW = (PARENTS > 1) ? $clog2(PARENTS) : 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] cfg_level = '0;
  logic in_valid = 1'b0, in_inject = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] in_src = '0, in_dst = '0;
  logic [CW-1:0] in_up_rem = '0;
  logic in_ready, out_valid;
  logic [1:0] out_kind;
  logic [DW-1:0] out_port;
  logic [PW-1:0] out_parent;
  logic [CW-1:0] out_up_rem;
  logic [AW-1:0] out_dst;

  always #2.5 clk = ~clk;

  tree_route_unit #(.RADIX(RADIX), .LEVELS(LEVELS), .PARENTS(PARENTS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .in_valid(in_valid),
    .in_ready(in_ready), .in_inject(in_inject), .in_src(in_src), .in_dst(in_dst),
    .in_up_rem(in_up_rem), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_port(out_port), .out_parent(out_parent),
    .out_up_rem(out_up_rem), .out_dst(out_dst)
  );

  int n_cmp = 0, n_bad = 0;
  // reference state
  int e_valid = 0, e_kind = 0, e_port = 0, e_parent = 0, e_rem = 0, e_dst = 0;
  int rr = 0;
  string e_req = "R1";

  function automatic int ref_climb(int s, int d);
    int x = s ^ d;
    int hb = -1;
    for (int b = 0; b < AW; b++) if (((x >> b) & 1) == 1) hb = b;
    return (hb < 0) ? 0 : hb / DW + 1;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    cmp("R3", "out_valid", int'(out_valid), e_valid);
    if (e_valid != 0) begin
      cmp(e_req, "out_kind", int'(out_kind), e_kind);
      cmp(e_req, "out_up_rem", int'(out_up_rem), e_rem);
      cmp((e_kind == 2) ? "R7" : "R9", "out_port", int'(out_port), e_port);
      cmp((e_kind == 1) ? "R8" : "R9", "out_parent", int'(out_parent), e_parent);
      cmp("R9", "out_dst", int'(out_dst), e_dst);
    end
  endtask

  task automatic step(bit v, bit inj, int s, int d, int rem, int lvl, bit ordy);
    bit acc;
    int c;
    check_outputs();
    in_valid = v; in_inject = inj; in_src = AW'(s); in_dst = AW'(d);
    in_up_rem = CW'(rem); cfg_level = LW'(lvl); out_ready = ordy;
    #1;
    cmp("R2", "in_ready", int'(in_ready), (e_valid == 0 || ordy) ? 1 : 0);
    acc = v && (e_valid == 0 || ordy);
    if (acc) begin
      e_valid = 1; e_dst = d; e_port = 0; e_parent = 0;
      if (inj) begin
        c = ref_climb(s, d);
        if (c == 0) begin e_kind = 0; e_rem = 0; e_req = "R5"; end
        else begin e_kind = 1; e_rem = c - 1; e_req = "R4"; end
      end else if (rem > 0) begin
        e_kind = 1; e_rem = rem - 1; e_req = "R6";
      end else begin
        e_kind = 2; e_rem = 0; e_req = "R7";
        e_port = (d >> (lvl * DW)) % RADIX;
      end
      if (e_kind == 1) begin e_parent = rr; rr = (rr + 1) % PARENTS; end
    end else if (ordy) begin
      e_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "out_valid after reset", int'(out_valid), 0);
    cmp("R1", "in_ready after reset", int'(in_ready), 1);
    // R5 equal addresses, R4 climbs of several heights
    step(1, 1, 'h55, 'h55, 0, 0, 1);
    step(1, 1, 'h00, 'hC0, 0, 0, 1);   // top digit differs: climb 4, first UP uses parent 0 (R1)
    step(1, 1, 'h12, 'h13, 0, 0, 1);   // digit 0: climb 1
    step(1, 1, 'h00, 'h20, 0, 0, 1);   // digit 2: climb 3
    // R6 transit climbs ignore addresses
    step(1, 0, 'hAA, 'hAA, 3, 2, 1);
    step(1, 0, 'h01, 'hF0, 1, 0, 1);
    // R7 descend: distinct digit per level (dst digits 3,2,1,0)
    for (int l = 0; l < LEVELS; l++) step(1, 0, 'h00, 'hE4, 0, l, 1);
    // R8 wrap, interleaved with non-UP traffic
    step(1, 0, 'h00, 'h00, 2, 0, 1);
    step(1, 1, 'h33, 'h33, 0, 0, 1);
    step(1, 0, 'h00, 'h00, 4, 0, 1);
    // R2 back-pressure: output held, new header not taken
    step(1, 0, 'h00, 'h9C, 0, 1, 0);
    step(1, 1, 'h00, 'hFF, 0, 0, 0);
    step(1, 1, 'h00, 'hFF, 0, 0, 0);
    step(1, 1, 'h00, 'hFF, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);          // R3 drain
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int s, d;
      s = $urandom_range(0, (1 << AW) - 1);
      d = ($urandom_range(0, 7) == 0) ? s : $urandom_range(0, (1 << AW) - 1);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1), s, d,
           $urandom_range(0, LEVELS), $urandom_range(0, LEVELS - 1),
           $urandom_range(0, 2) != 0);
    end
    check_outputs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule